// File: doc/BRIEF.md
# Dual Cascadable Countdown Timer

This block holds two 8-bit down-counters that share one control register. Each timer has a reload divisor, a mode bit that either parks the counter on its divisor or lets it run, an interrupt-acknowledge bit and a 2-bit clock-source select. The sources are three fixed tick-enable inputs and one alternative source. For timer 0 the alternative source is a flexible tick from a 16-bit programmable prescaler. For timer 1 it is the underflow of timer 0, so the two timers can be cascaded. When a running timer reaches the end of its period it reloads from its divisor and sets a sticky interrupt flag. The flag stays set until software acknowledges it.

Software uses one register port: a write enable, a 2-bit address and write data, with a combinational read port. The counts, the flags and the prescaler's live count can all be read back. A read of a counter at any moment gives the elapsed ticks since the last reload as divisor minus count. The tick-enable inputs are one-cycle pulses at the clock rate. They stand in for the oscillator-derived rates.

Top module: `duo_tick_timer`

## Requirements
- R1: After synchronous reset all four readable registers return 0 and both interrupt outputs are low.
- R2: While a timer's mode bit is 0 (stop-and-load), its counter holds its divisor field, loaded on the clock edge after the divisor is present in the control register. Ticks do not change it.
- R3: While the mode bit is 1 (run), the counter falls by exactly one on each cycle in which its selected tick is high. On cycles without a selected tick it keeps its value.
- R4: A selected tick that arrives while the count is 1 is an underflow. On that edge the counter reloads its divisor and the interrupt flag sets. The flag never sets without an underflow, so a divisor D gives one interrupt every D ticks (for example, 250 ticks of a 25 kHz enable give 100 Hz).
- R5: A divisor field of 0 acts as 256. The counter wraps from 0 to 255 on the first tick, and the underflow comes on the 256th tick.
- R6: Select values 0, 1 and 2 pick fixed tick input 0, 1 or 2. Value 3 picks the prescaler's flexible tick for timer 0, and the same-cycle underflow of timer 0 for timer 1.
- R7: A write to the prescaler register loads both its reload value and its live count. Each base tick lowers the count by one. A base tick at count 1 emits one flexible tick and reloads the count, and a value of 0 acts as 65536.
- R8: A control write with a timer's acknowledge bit at 1 clears that timer's flag on the next edge. An acknowledge bit of 0 leaves the flag unchanged.
- R9: If an acknowledge write and an underflow of the same timer fall on the same edge, the flag ends up set.
- R10: The register map is as follows. Address 0 is control: [7:0] divisor 0, [15:8] divisor 1, [16]/[17] acknowledge 0/1 (these read back as 0), [18]/[19] mode 0/1, [21:20] select 0, [23:22] select 1. Address 1 is the prescaler reload value in [15:0]. Address 2 is read-only, with count 0 in [7:0], count 1 in [15:8] and flags 0/1 in [16]/[17]. Address 3 is the read-only live prescaler count. `irq_o` mirrors the two flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fix_i | input | 3 | Fixed-rate tick enables, selected by select values 0 to 2 |
| tick_base_i | input | 1 | Base tick enable that drives the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for both read and write |
| wdata_i | input | 24 | Register write data |
| rdata_o | output | 24 | Combinational read data for `addr_i` |
| irq_o | output | 2 | Sticky interrupt flags, one per timer |

## Verification
Every write, tick and acknowledge takes effect on the single clock edge on which it is presented. The one exception is stop-and-load after a divisor write: the count reflects the new divisor one edge later, because the control register must update first. The bench drives each cycle's inputs, advances its reference model by that same edge, and then reads the counts, the prescaler count, the control readback and `irq_o` one nanosecond after the edge. Since the read port has no register in its path, every result is compared in the cycle it is due. The directed period checks step up to the tick just before an underflow and then one tick past it, so an off-by-one in either direction shows up.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

    localparam int CNT_W   = 8;
    localparam int NUM_TMR = 2;
    localparam int NUM_FIX = 3;
    localparam int SEL_W   = 2;
    localparam int PRE_W   = 16;
    localparam int ADDR_W  = 2;

    localparam logic [SEL_W-1:0] SEL_ALT = SEL_W'(NUM_FIX);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_PRESC = 2'd1,
        REG_COUNT = 2'd2,
        REG_PSTAT = 2'd3
    } reg_addr_e;

    // Field order fixes the bit layout: last member is least significant.
    typedef struct packed {
        logic [NUM_TMR-1:0][SEL_W-1:0] sel;
        logic [NUM_TMR-1:0]            run;
        logic [NUM_TMR-1:0]            ack;
        logic [NUM_TMR-1:0][CNT_W-1:0] div;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int DATA_W = CTRL_W;

    typedef logic [NUM_TMR-1:0][CNT_W-1:0] cnt_vec_t;

    // Stored control image: acknowledge bits are strobes, never held.
    function automatic ctrl_t ctrl_store(input logic [DATA_W-1:0] raw);
        ctrl_t c;
        c     = ctrl_t'(raw[CTRL_W-1:0]);
        c.ack = '0;
        return c;
    endfunction

    // Next count of a down-counter that reloads instead of reaching zero.
    function automatic logic [CNT_W-1:0] count_next(
        input logic             run,
        input logic             tick,
        input logic [CNT_W-1:0] cur,
        input logic [CNT_W-1:0] div
    );
        if (!run)
            return div;
        else if (!tick)
            return cur;
        else if (cur == CNT_W'(1))
            return div;
        else
            return cur - CNT_W'(1);
    endfunction

endpackage

// File: rtl/duo_prescaler.sv
module duo_prescaler
    import duo_timer_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         base_tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] live_cnt,
    output logic [W-1:0] reload,
    output logic         flex_tick
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] rel_q;
    logic         wrap;

    assign wrap      = base_tick && (cnt_q == ONE);
    assign flex_tick = wrap;
    assign live_cnt  = cnt_q;
    assign reload    = rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rel_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            rel_q <= load_val;
        end else if (base_tick) begin
            cnt_q <= wrap ? rel_q : cnt_q - ONE;
        end
    end

endmodule

// File: rtl/duo_countdown.sv
module duo_countdown
    import duo_timer_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int NFIX = NUM_FIX,
    parameter int SW   = SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [W-1:0]    div,
    input  logic [SW-1:0]   sel,
    input  logic [NFIX-1:0] fix_tick,
    input  logic            alt_tick,
    input  logic            ack_wr,
    output logic [W-1:0]    cnt,
    output logic            flag,
    output logic            uf,
    output logic            tk
);

    localparam logic [SW-1:0] ALT_CODE = SW'(NFIX);

    logic         src;
    logic [W-1:0] cnt_q;
    logic         flag_q;

    always_comb begin
        src = 1'b0;
        if (sel == ALT_CODE) begin
            src = alt_tick;
        end else begin
            for (int k = 0; k < NFIX; k++) begin
                if (sel == SW'(k)) src = fix_tick[k];
            end
        end
    end

    assign tk   = run && src;
    assign uf   = tk && (cnt_q == W'(1));
    assign cnt  = cnt_q;
    assign flag = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q <= count_next(run, tk, cnt_q, div);
            if (uf)
                flag_q <= 1'b1;
            else if (ack_wr)
                flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/duo_regs.sv
module duo_regs
    import duo_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  cnt_vec_t           cnt,
    input  logic [NUM_TMR-1:0] flag,
    input  logic [PRE_W-1:0]   pre_live,
    input  logic [PRE_W-1:0]   pre_reload,
    output ctrl_t              ctrl,
    output logic [NUM_TMR-1:0] ack_wr,
    output logic               pre_load,
    output logic [DATA_W-1:0]  rdata
);

    ctrl_t ctrl_q;
    ctrl_t wr_img;
    logic  ctrl_wr;

    assign wr_img   = ctrl_t'(wdata[CTRL_W-1:0]);
    assign ctrl_wr  = wr_en && (reg_addr_e'(addr) == REG_CTRL);
    assign pre_load = wr_en && (reg_addr_e'(addr) == REG_PRESC);
    assign ack_wr   = ctrl_wr ? wr_img.ack : '0;
    assign ctrl     = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_store(wdata);
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            REG_CTRL:  rdata = DATA_W'(ctrl_q);
            REG_PRESC: rdata = DATA_W'(pre_reload);
            REG_COUNT: rdata = DATA_W'({flag, cnt});
            REG_PSTAT: rdata = DATA_W'(pre_live);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/duo_tick_timer.sv
module duo_tick_timer
    import duo_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_FIX-1:0] tick_fix_i,
    input  logic               tick_base_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [NUM_TMR-1:0] irq_o
);

    ctrl_t              ctrl_q;
    cnt_vec_t           cnt;
    logic [NUM_TMR-1:0] flag;
    logic [NUM_TMR-1:0] uf;
    logic [NUM_TMR-1:0] tk;
    logic [NUM_TMR-1:0] alt;
    logic [NUM_TMR-1:0] ack_wr;
    logic               pre_load;
    logic               flex_tick;
    logic [PRE_W-1:0]   pre_live;
    logic [PRE_W-1:0]   pre_reload;

    duo_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en_i),
        .addr       (addr_i),
        .wdata      (wdata_i),
        .cnt        (cnt),
        .flag       (flag),
        .pre_live   (pre_live),
        .pre_reload (pre_reload),
        .ctrl       (ctrl_q),
        .ack_wr     (ack_wr),
        .pre_load   (pre_load),
        .rdata      (rdata_o)
    );

    duo_prescaler #(.W(PRE_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .base_tick (tick_base_i),
        .load      (pre_load),
        .load_val  (wdata_i[PRE_W-1:0]),
        .live_cnt  (pre_live),
        .reload    (pre_reload),
        .flex_tick (flex_tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        if (i == 0) begin : g_flex
            assign alt[i] = flex_tick;
        end else begin : g_casc
            assign alt[i] = uf[i-1];
        end

        duo_countdown #(.W(CNT_W), .NFIX(NUM_FIX), .SW(SEL_W)) u_cd (
            .clk      (clk),
            .rst      (rst),
            .run      (ctrl_q.run[i]),
            .div      (ctrl_q.div[i]),
            .sel      (ctrl_q.sel[i]),
            .fix_tick (tick_fix_i),
            .alt_tick (alt[i]),
            .ack_wr   (ack_wr[i]),
            .cnt      (cnt[i]),
            .flag     (flag[i]),
            .uf       (uf[i]),
            .tk       (tk[i])
        );
    end

    assign irq_o = flag;

endmodule

// File: rtl/duo_tick_timer_chk.sv
module duo_tick_timer_chk
    import duo_timer_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input ctrl_t              ctrl,
    input cnt_vec_t           cnt,
    input logic [NUM_TMR-1:0] flag,
    input logic [NUM_TMR-1:0] uf,
    input logic [NUM_TMR-1:0] tk,
    input logic [NUM_TMR-1:0] ack_wr
);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        assert_park_on_div_R2: assert property (@(posedge clk) disable iff (rst)
            !ctrl.run[i] |=> cnt[i] == $past(ctrl.div[i]));

        assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
            (ctrl.run[i] && !tk[i]) |=> $stable(cnt[i]));

        assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
            (tk[i] && cnt[i] != CNT_W'(1)) |=> cnt[i] == $past(cnt[i]) - CNT_W'(1));

        assert_reload_and_flag_R4: assert property (@(posedge clk) disable iff (rst)
            uf[i] |=> (flag[i] && cnt[i] == $past(ctrl.div[i])));

        assert_no_spurious_flag_R4: assert property (@(posedge clk) disable iff (rst)
            (!flag[i] && !uf[i]) |=> !flag[i]);

        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (ack_wr[i] && !uf[i]) |=> !flag[i]);

        assert_underflow_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (ack_wr[i] && uf[i]) |=> flag[i]);

        if (i > 0) begin : g_casc
            assert_cascade_step_R6: assert property (@(posedge clk) disable iff (rst)
                (ctrl.run[i] && ctrl.sel[i] == SEL_ALT && uf[i-1] && cnt[i] != CNT_W'(1))
                |=> cnt[i] == $past(cnt[i]) - CNT_W'(1));
        end
    end

endmodule

bind duo_tick_timer duo_tick_timer_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl_q),
    .cnt    (cnt),
    .flag   (flag),
    .uf     (uf),
    .tk     (tk),
    .ack_wr (ack_wr)
);

// File: tb/sim_duo_tick_timer.sv
`timescale 1ns/1ps
module sim_duo_tick_timer;
    import duo_timer_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_FIX-1:0] tick_fix = '0;
    logic               tick_base = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic [NUM_TMR-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [CNT_W-1:0] mc [NUM_TMR];
    logic             mf [NUM_TMR];
    ctrl_t            mctrl;
    logic [PRE_W-1:0] mpc, mpv;

    always #5 clk = ~clk;

    duo_tick_timer u0 (
        .clk         (clk),
        .rst         (rst),
        .tick_fix_i  (tick_fix),
        .tick_base_i (tick_base),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v);
        wr_en = 1'b0;
        addr  = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [DATA_W-1:0] mk(
        input logic [7:0] d0, input logic [7:0] d1,
        input logic r0, input logic r1, input logic a0, input logic a1,
        input logic [1:0] s0, input logic [1:0] s1);
        ctrl_t c;
        c.div[0] = d0; c.div[1] = d1;
        c.run[0] = r0; c.run[1] = r1;
        c.ack[0] = a0; c.ack[1] = a1;
        c.sel[0] = s0; c.sel[1] = s1;
        return DATA_W'(c);
    endfunction

    // Reference: state after the coming edge, from the requirements.
    task automatic model_upd(input logic w, input logic [1:0] a, input logic [DATA_W-1:0] d,
                             input logic [2:0] fx, input logic b);
        logic flex, src, t;
        logic [NUM_TMR-1:0] u;
        ctrl_t wi;
        wi = ctrl_t'(d[CTRL_W-1:0]);
        flex = b && (mpc == PRE_W'(1));
        u = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            if (mctrl.sel[i] == 2'd3) src = (i == 0) ? flex : u[0];
            else src = fx[mctrl.sel[i]];
            t = mctrl.run[i] && src;
            u[i] = t && (mc[i] == 8'd1);
            if (!mctrl.run[i]) mc[i] = mctrl.div[i];
            else if (t) mc[i] = (mc[i] == 8'd1) ? mctrl.div[i] : mc[i] - 8'd1;
            if (u[i]) mf[i] = 1'b1;
            else if (w && a == 2'd0 && wi.ack[i]) mf[i] = 1'b0;
        end
        if (w && a == 2'd1) begin
            mpv = d[PRE_W-1:0];
            mpc = d[PRE_W-1:0];
        end else if (b) begin
            mpc = (mpc == PRE_W'(1)) ? mpv : mpc - PRE_W'(1);
        end
        if (w && a == 2'd0) begin
            mctrl = wi;
            mctrl.ack = '0;
        end
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [DATA_W-1:0] d,
                        input logic [2:0] fx, input logic b, input string tag);
        logic [DATA_W-1:0] v;
        wr_en = w; addr = a; wdata = d; tick_fix = fx; tick_base = b;
        model_upd(w, a, d, fx, b);
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_fix = '0; tick_base = 1'b0;
        peek(2'd2, v);
        chk({tag, " count reg"}, 32'(v), 32'({mf[1], mf[0], mc[1], mc[0]}));
        peek(2'd3, v);
        chk({tag, " prescaler live R7"}, 32'(v), 32'(mpc));
        peek(2'd0, v);
        chk({tag, " ctrl readback R10"}, 32'(v), 32'(mctrl));
        chk({tag, " irq pins R10"}, 32'(irq), 32'({mf[1], mf[0]}));
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 2'd0, '0, 3'b000, 1'b0, tag);
    endtask

    // n ticks on fixed input bit fb, gap idle cycles after each
    task automatic ticks(input int n, input int fb, input int gap, input string tag);
        for (int k = 0; k < n; k++) begin
            step(1'b0, 2'd0, '0, 3'(1 << fb), 1'b0, tag);
            if (gap > 0) idle(gap, tag);
        end
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        for (int i = 0; i < NUM_TMR; i++) begin mc[i] = '0; mf[i] = 1'b0; end
        mctrl = '0; mpc = '0; mpv = '0;
        void'($urandom(32'd4711));

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values
        for (int r = 0; r < 4; r++) begin
            peek(2'(r), v);
            chk("R1 reset register", 32'(v), 32'd0);
        end
        chk("R1 reset irq", 32'(irq), 32'd0);
        @(posedge clk); #1;

        // R2: stop-and-load parks the counter on the divisor
        step(1'b1, 2'd0, mk(8'd250, 8'd0, 0, 0, 0, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R2");
        step(1'b0, 2'd0, '0, 3'b111, 1'b0, "R2");
        peek(2'd2, v);
        chk("R2 parked count", 32'(v[7:0]), 32'd250);

        // R3/R4: run from 250, 25 kHz-like tick every 4th cycle
        step(1'b1, 2'd0, mk(8'd250, 8'd0, 1, 0, 0, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R3");
        ticks(1, 0, 3, "R3");
        peek(2'd2, v);
        chk("R3 one tick", 32'(v[7:0]), 32'd249);
        ticks(248, 0, 3, "R4");
        peek(2'd2, v);
        chk("R4 count before underflow", 32'(v[7:0]), 32'd1);
        chk("R4 no irq before underflow", 32'(irq[0]), 32'd0);
        ticks(1, 0, 0, "R4");
        peek(2'd2, v);
        chk("R4 reload", 32'(v[7:0]), 32'd250);
        chk("R4 irq at 250th tick", 32'(irq[0]), 32'd1);

        // R8: ack bit 0 keeps, ack bit 1 clears
        step(1'b1, 2'd0, mk(8'd250, 8'd0, 1, 0, 0, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R8");
        chk("R8 no-op ack keeps flag", 32'(irq[0]), 32'd1);
        step(1'b1, 2'd0, mk(8'd250, 8'd0, 1, 0, 1, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R8");
        chk("R8 ack clears flag", 32'(irq[0]), 32'd0);

        // R5: divisor 0 means 256
        step(1'b1, 2'd0, mk(8'd0, 8'd0, 0, 0, 1, 0, 2'd2, 2'd0), 3'b000, 1'b0, "R5");
        idle(1, "R5");
        step(1'b1, 2'd0, mk(8'd0, 8'd0, 1, 0, 0, 0, 2'd2, 2'd0), 3'b000, 1'b0, "R5");
        ticks(1, 2, 0, "R5");
        peek(2'd2, v);
        chk("R5 wrap to 255", 32'(v[7:0]), 32'd255);
        ticks(254, 2, 0, "R5");
        chk("R5 no irq at 255 ticks", 32'(irq[0]), 32'd0);
        ticks(1, 2, 0, "R5");
        chk("R5 irq at 256 ticks", 32'(irq[0]), 32'd1);

        // R6: cascade, timer0 div 3 on fix1, timer1 div 2 on timer0 underflow
        step(1'b1, 2'd0, mk(8'd3, 8'd2, 0, 0, 1, 1, 2'd1, 2'd3), 3'b000, 1'b0, "R6");
        idle(1, "R6");
        step(1'b1, 2'd0, mk(8'd3, 8'd2, 1, 1, 0, 0, 2'd1, 2'd3), 3'b000, 1'b0, "R6");
        ticks(3, 1, 0, "R6");
        peek(2'd2, v);
        chk("R6 timer1 steps on cascade", 32'(v[15:8]), 32'd1);
        ticks(2, 1, 0, "R6");
        chk("R6 no irq1 at 5 ticks", 32'(irq[1]), 32'd0);
        ticks(1, 1, 0, "R6");
        chk("R6 irq1 at 6 ticks", 32'(irq[1]), 32'd1);

        // R7: prescaler 5, timer0 div 2 on flexible tick
        step(1'b1, 2'd1, DATA_W'(5), 3'b000, 1'b0, "R7");
        step(1'b1, 2'd0, mk(8'd2, 8'd0, 0, 0, 1, 1, 2'd3, 2'd0), 3'b000, 1'b0, "R7");
        step(1'b1, 2'd0, mk(8'd2, 8'd0, 1, 0, 0, 0, 2'd3, 2'd0), 3'b000, 1'b0, "R7");
        peek(2'd1, v);
        chk("R7 reload readback", 32'(v), 32'd5);
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, '0, 3'b000, 1'b1, "R7");
        peek(2'd3, v);
        chk("R7 live count after 3", 32'(v), 32'd2);
        for (int k = 0; k < 6; k++) step(1'b0, 2'd0, '0, 3'b000, 1'b1, "R7");
        chk("R7 no irq at 9 base ticks", 32'(irq[0]), 32'd0);
        step(1'b0, 2'd0, '0, 3'b000, 1'b1, "R7");
        chk("R7 irq at 10 base ticks", 32'(irq[0]), 32'd1);
        peek(2'd3, v);
        chk("R7 live count reloaded", 32'(v), 32'd5);

        // R9: ack and underflow on the same edge
        step(1'b1, 2'd0, mk(8'd1, 8'd0, 0, 0, 1, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R9");
        idle(1, "R9");
        step(1'b1, 2'd0, mk(8'd1, 8'd0, 1, 0, 0, 0, 2'd0, 2'd0), 3'b000, 1'b0, "R9");
        ticks(1, 0, 0, "R9");
        step(1'b1, 2'd0, mk(8'd1, 8'd0, 1, 0, 1, 0, 2'd0, 2'd0), 3'b001, 1'b0, "R9");
        chk("R9 underflow beats ack", 32'(irq[0]), 32'd1);

        // random phase against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            logic w;
            logic [1:0] a;
            logic [DATA_W-1:0] d;
            r = $urandom;
            w = (r[2:0] == 3'd0);
            a = {1'b0, r[3]};
            d = DATA_W'($urandom);
            if (a == 2'd0) begin
                d[7:0]  = {5'd0, r[6:4]};
                d[15:8] = {5'd0, r[9:7]};
            end else begin
                d[15:0] = {13'd0, r[12:10]};
            end
            step(w, a, d, r[15:13], r[16], "R3 R4 R6 R8 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule